// File: doc/BRIEF.md
# Host Port Interrupt Register Block

This block is a small memory-mapped register file that drives one level-sensitive interrupt line, used as the fast interrupt request for a USB host controller driver. Software reaches it over a plain 32-bit register bus with a byte address, a write strobe with write data, and a read strobe whose data returns one cycle later. The block holds five 32-bit words: two outbound descriptor words (A and B), a control word, an interrupt status word and a software interrupt word. The software interrupt word is reached through two aliased offsets, one that sets bits and one that clears them.

The interrupt line is not computed from status and enable bits. It is a registered level. Certain writes, or certain bits in the written data, raise it or drop it. Every other access leaves it as it was. No data moves through the block. It performs no DMA, FIFO or port signalling.

Top module: `host_irq_regs`

## Requirements
- R1: While reset is held and after it is released, all five stored words read as zero (control reads 0x0002_0000 because of R5), and `irq` is low.
- R2: A read strobe at mapped offset 0x28 (descriptor A), 0x2C (descriptor B), 0x4C (control), 0x50 (status), 0x1F0 (software set) or 0x1F4 (software clear) returns the value on `rd_data` one cycle after the strobe. In cycles that follow no read, `rd_data` is zero. A read issued together with a write to the same offset returns the value held before the write.
- R3: A write to descriptor A stores the full word and never changes `irq`.
- R4: A write to descriptor B stores the full word. When bit 29 of the data is 1, `irq` is high in the next cycle. When bit 29 is 0, `irq` keeps its value.
- R5: A write to control stores the full word. When bit 16 of the data is 1, `irq` is low in the next cycle. A read of control returns the stored word with bit 17 forced to 1.
- R6: A write to status stores the word exactly as written (the bits are not write-one-to-clear). When bit 16 or bit 29 of the data is 1, `irq` is low in the next cycle.
- R7: A write to the set offset ORs the data into the software interrupt word and always drives `irq` high in the next cycle, even when the data is zero.
- R8: A write to the clear offset clears the software interrupt bits where the data has ones and always drives `irq` low in the next cycle. Reads of the set offset and of the clear offset both return the software interrupt word.
- R9: `irq` changes only after a write that R4 to R8 name as raising or lowering it. Idle cycles, reads and writes without a trigger bit leave it unchanged.
- R10: Only exact word offsets decode. A write to any other address, including a misaligned one next to a mapped offset, changes no stored word and not `irq`. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address of the access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Registered interrupt level |

## Verification
A wrong interrupt state shows on `irq` in the cycle after the write that caused it. It can also stay hidden until the next write that does not touch the line. For that reason the line is checked after every write, including writes that must leave it alone. A corrupted stored word shows only when that offset is read, one cycle after the strobe. So each write is followed by a read-back through the offset that matters, and the set and clear aliases are read against each other. Decode faults are exposed by misaligned writes that carry trigger bits, followed by reads of the neighbouring mapped words.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_SEL  = 6;

    // select indices, one per decoded offset
    localparam int unsigned SEL_DESC_A = 0;
    localparam int unsigned SEL_DESC_B = 1;
    localparam int unsigned SEL_CTRL   = 2;
    localparam int unsigned SEL_STAT   = 3;
    localparam int unsigned SEL_SW_SET = 4;
    localparam int unsigned SEL_SW_CLR = 5;

    localparam logic [11:0] OFFSETS [NUM_SEL] = '{
        12'h028, 12'h02C, 12'h04C, 12'h050, 12'h1F0, 12'h1F4
    };

    // bit positions that steer the interrupt line
    localparam int unsigned RAISE_BIT   = 29;
    localparam int unsigned LOWER_BIT   = 16;
    localparam int unsigned CTRL_RO_BIT = 17;

    localparam logic [DATA_W-1:0] CTRL_FORCE = DATA_W'(1) << CTRL_RO_BIT;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t desc_a;
        word_t desc_b;
        word_t ctrl;
        word_t status;
        word_t swirq;
        word_t rdata;
        logic  irq;
    } hpi_state_t;

endpackage

// File: rtl/hpi_addr_decode.sv
module hpi_addr_decode
    import hpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] hit
);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(OFFSETS[i]));
    end

endmodule

// File: rtl/hpi_irq_ctrl.sv
module hpi_irq_ctrl
    import hpi_pkg::*;
(
    input  logic  wr_en,
    input  logic  hit_desc_b,
    input  logic  hit_ctrl,
    input  logic  hit_stat,
    input  logic  hit_set,
    input  logic  hit_clr,
    input  logic  bit_raise,
    input  logic  bit_lower,
    input  logic  irq_q,
    output logic  irq_d
);

    logic raise;
    logic lower;

    always_comb begin
        raise = wr_en & ((hit_desc_b & bit_raise) | hit_set);
        lower = wr_en & ((hit_ctrl & bit_lower)
                       | (hit_stat & (bit_lower | bit_raise))
                       | hit_clr);
        if (raise) begin
            irq_d = 1'b1;
        end else if (lower) begin
            irq_d = 1'b0;
        end else begin
            irq_d = irq_q;
        end
    end

endmodule

// File: rtl/hpi_read_mux.sv
module hpi_read_mux
    import hpi_pkg::*;
(
    input  logic [NUM_SEL-1:0] hit,
    input  word_t              desc_a,
    input  word_t              desc_b,
    input  word_t              ctrl,
    input  word_t              status,
    input  word_t              swirq,
    output word_t              value
);

    always_comb begin
        value = '0;
        if (hit[SEL_DESC_A]) value = desc_a;
        if (hit[SEL_DESC_B]) value = desc_b;
        if (hit[SEL_CTRL])   value = ctrl | CTRL_FORCE;
        if (hit[SEL_STAT])   value = status;
        if (hit[SEL_SW_SET] || hit[SEL_SW_CLR]) value = swirq;
    end

endmodule

// File: rtl/host_irq_regs.sv
module host_irq_regs
    import hpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              irq
);

    hpi_state_t   st_d;
    hpi_state_t   st_q;
    logic [NUM_SEL-1:0] hit;
    word_t        rd_value;
    logic         irq_next;

    hpi_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .hit  (hit)
    );

    hpi_read_mux u_rmux (
        .hit    (hit),
        .desc_a (st_q.desc_a),
        .desc_b (st_q.desc_b),
        .ctrl   (st_q.ctrl),
        .status (st_q.status),
        .swirq  (st_q.swirq),
        .value  (rd_value)
    );

    hpi_irq_ctrl u_irq (
        .wr_en      (wr_en),
        .hit_desc_b (hit[SEL_DESC_B]),
        .hit_ctrl   (hit[SEL_CTRL]),
        .hit_stat   (hit[SEL_STAT]),
        .hit_set    (hit[SEL_SW_SET]),
        .hit_clr    (hit[SEL_SW_CLR]),
        .bit_raise  (wr_data[RAISE_BIT]),
        .bit_lower  (wr_data[LOWER_BIT]),
        .irq_q      (st_q.irq),
        .irq_d      (irq_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = irq_next;
        st_d.rdata = rd_en ? rd_value : '0;
        if (wr_en) begin
            if (hit[SEL_DESC_A]) st_d.desc_a = wr_data;
            if (hit[SEL_DESC_B]) st_d.desc_b = wr_data;
            if (hit[SEL_CTRL])   st_d.ctrl   = wr_data;
            if (hit[SEL_STAT])   st_d.status = wr_data;
            if (hit[SEL_SW_SET]) st_d.swirq  = st_q.swirq | wr_data;
            if (hit[SEL_SW_CLR]) st_d.swirq  = st_q.swirq & ~wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign irq     = st_q.irq;

endmodule

// File: rtl/hpi_checker.sv
module hpi_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wbit29,
    input  logic              wbit16,
    input  logic              rd_en,
    input  logic [31:0]       rd_data,
    input  logic              irq
);

    logic a_desc_a, a_desc_b, a_ctrl, a_stat, a_set, a_clr, a_mapped;
    assign a_desc_a = (addr == ADDR_W'(12'h028));
    assign a_desc_b = (addr == ADDR_W'(12'h02C));
    assign a_ctrl   = (addr == ADDR_W'(12'h04C));
    assign a_stat   = (addr == ADDR_W'(12'h050));
    assign a_set    = (addr == ADDR_W'(12'h1F0));
    assign a_clr    = (addr == ADDR_W'(12'h1F4));
    assign a_mapped = a_desc_a | a_desc_b | a_ctrl | a_stat | a_set | a_clr;

    AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq); // R1
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 32'h0); // R2
    AST_DESC_A_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_desc_a) |=> $stable(irq)); // R3
    AST_DESC_B_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_desc_b && wbit29) |=> irq); // R4
    AST_CTRL_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_ctrl && wbit16) |=> !irq); // R5
    AST_CTRL_RO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a_ctrl) |=> rd_data[17]); // R5
    AST_STAT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_stat && (wbit16 || wbit29)) |=> !irq); // R6
    AST_SET_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_set) |=> irq); // R7
    AST_CLR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_clr) |=> !irq); // R8
    AST_IRQ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq)); // R9
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a_mapped) |=> $stable(irq)); // R10
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !a_mapped) |=> rd_data == 32'h0); // R10

endmodule

bind host_irq_regs hpi_checker #(.ADDR_W(ADDR_W)) u_hpi_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wbit29  (wr_data[29]),
    .wbit16  (wr_data[16]),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/host_irq_regs_bench.sv
module host_irq_regs_bench;

    localparam int unsigned ADDR_W = 12;
    localparam logic [11:0] O_DA  = 12'h028;
    localparam logic [11:0] O_DB  = 12'h02C;
    localparam logic [11:0] O_CT  = 12'h04C;
    localparam logic [11:0] O_ST  = 12'h050;
    localparam logic [11:0] O_SET = 12'h1F0;
    localparam logic [11:0] O_CLR = 12'h1F4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic              irq;

    int tests  = 0;
    int fails  = 0;
    int cycle  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
        int          due;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    host_irq_regs #(.ADDR_W(ADDR_W)) u_host_irq_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cycle) begin
            exp_t e;
            e = sb_q.pop_front();
            tests++;
            if (rd_data !== e.val) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.val);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag; e.due = cycle + 1;
        sb_q.push_back(e);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        @(negedge clk);
        tests++;
        if (rd_data !== 32'h0) begin
            fails++;
            $display("FAIL %s idle rd_data actual=%h expected=0", tag, rd_data);
        end
    endtask

    initial begin
        #1;
        chk_irq(1'b0, "R1 irq in reset");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk_irq(1'b0, "R1 irq after reset");
        rd(O_DA,  32'h0, "R1 desc A reset");
        rd(O_DB,  32'h0, "R1 desc B reset");
        rd(O_ST,  32'h0, "R1 status reset");
        rd(O_SET, 32'h0, "R1 swirq reset");
        rd(O_CT,  32'h0002_0000, "R1 R5 ctrl reset");
        chk_idle("R2");

        wr(O_DA, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R3 desc A write");
        rd(O_DA, 32'hFFFF_FFFF, "R3 desc A stored");

        wr(O_DB, 32'h2000_0000);
        chk_irq(1'b1, "R4 desc B bit29 raises");
        wr(O_DB, 32'h0000_1234);
        chk_irq(1'b1, "R4 R9 desc B no bit29 holds");
        rd(O_DB, 32'h0000_1234, "R4 desc B stored");

        wr(O_CT, 32'h0000_0005);
        chk_irq(1'b1, "R5 R9 ctrl no bit16 holds");
        wr(O_CT, 32'h0001_0000);
        chk_irq(1'b0, "R5 ctrl bit16 lowers");
        rd(O_CT, 32'h0003_0000, "R5 ctrl read forced bit17");

        wr(O_SET, 32'h0000_000F);
        chk_irq(1'b1, "R7 set raises");
        wr(O_SET, 32'h0000_00F0);
        rd(O_SET, 32'h0000_00FF, "R7 set ORs");
        rd(O_CLR, 32'h0000_00FF, "R8 clr alias read");

        wr(O_ST, 32'h0000_0001);
        chk_irq(1'b1, "R6 R9 status no trigger holds");
        rd(O_ST, 32'h0000_0001, "R6 status stored");
        wr(O_ST, 32'h2000_0000);
        chk_irq(1'b0, "R6 status bit29 lowers");
        rd(O_ST, 32'h2000_0000, "R6 status not w1c");

        wr(O_SET, 32'h0);
        chk_irq(1'b1, "R7 set with zero data raises");
        rd(O_SET, 32'h0000_00FF, "R7 zero set keeps word");
        wr(O_ST, 32'h0001_0000);
        chk_irq(1'b0, "R6 status bit16 lowers");

        wr(O_SET, 32'h0);
        wr(O_CLR, 32'h0000_000F);
        chk_irq(1'b0, "R8 clr lowers");
        rd(O_CLR, 32'h0000_00F0, "R8 clr clears bits");
        wr(O_CLR, 32'h0);
        chk_irq(1'b0, "R8 zero clr");
        rd(O_SET, 32'h0000_00F0, "R8 zero clr keeps word");

        // idle and reads do not move the line
        wr(O_SET, 32'h0);
        repeat (4) @(posedge clk);
        #1 chk_irq(1'b1, "R9 idle holds");
        rd(O_ST, 32'h0001_0000, "R9 read holds (status)");
        chk_irq(1'b1, "R9 read leaves irq");

        // unmapped and misaligned writes
        wr(12'h100, 32'h2001_0000);
        chk_irq(1'b1, "R10 unmapped write holds");
        wr(12'h051, 32'h2001_0000);
        chk_irq(1'b1, "R10 misaligned status write holds");
        wr(O_CLR, 32'h0);
        wr(12'h02D, 32'h2000_0000);
        chk_irq(1'b0, "R10 misaligned desc B write holds");
        rd(O_DB, 32'h0000_1234, "R10 desc B untouched");
        rd(O_ST, 32'h0001_0000, "R10 status untouched");
        rd(12'h100, 32'h0, "R10 unmapped read");
        rd(12'h029, 32'h0, "R10 misaligned read");

        // read together with write returns the old value
        addr = O_DA; wr_data = 32'h0BAD_F00D; wr_en = 1'b1;
        begin
            exp_t e;
            e.val = 32'hFFFF_FFFF; e.tag = "R2 read with write"; e.due = cycle + 1;
            sb_q.push_back(e);
        end
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk); #1;
        rd(O_DA, 32'h0BAD_F00D, "R2 R3 write landed");
        chk_idle("R2 after reads");

        // reset mid-run
        wr(O_SET, 32'h0000_0003);
        rst_n = 1'b0;
        #1 chk_irq(1'b0, "R1 async reset drops irq");
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;
        rd(O_SET, 32'h0, "R1 swirq after reset");
        rd(O_DA,  32'h0, "R1 desc A after reset");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard residue actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule